// File: doc/BRIEF.md
# Priority interrupt controller with test-mode force

This block gathers interrupt events on fifteen priority levels (1 to 15) into a set of sticky pending bits. It filters them through a mask and reports the most urgent surviving level to the processor as a 4-bit request code. The processor acknowledges by returning a level. That acknowledge retires the matching request.

A small register interface gives access to the controller. Software can read the pending bits and can read or write the mask. It can drop pending bits through a write-one-to-clear register, and it can switch a test mode on or off. While test mode is on, a separate force register can be loaded, and its bits join the pending bits as extra request sources. While test mode is on, an acknowledge retires a forced request before it touches the real pending bit of that level. A mask write that carries bits outside the storable field raises a one-cycle parity-error pulse.

The block has no state machine. Its state is four register groups: pending, mask, force and the test-mode flag. A registered request code sits behind them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_level` is 0, pending and force read 0, the test-control register reads 0, and the mask reads 0x0000_7FFE.
- R2: A high `src_evt[n]` for n in 1..15 sets pending bit n at the next clock edge. Bit 0 has no effect, and pending bit 0 always reads 0.
- R3: `irq_level` is the index of the highest set bit among bits 15..1 of (pending OR (force when test mode is on)) AND NOT mask, or 0 if none is set. It is registered and follows a register change one cycle later.
- R4: A write with `wr_sel` = 0 (mask) stores data bits 14..1 only. Mask bits 0 and 15 always read 0, so level 15 cannot be masked.
- R5: A mask write whose data has bit 0 or any of bits 31..15 set drives `par_err` high for exactly the one cycle after the write. No other write ever raises `par_err`.
- R6: A write with `wr_sel` = 2 (clear) clears every pending bit whose data bit (15..1) is 1. A source event on the same level in the same cycle wins over the clear. Reading select 2 returns 0.
- R7: Test mode is bit 19 of the test-control register (`wr_sel`/`rd_sel` = 4). A write with `wr_sel` = 3 loads force bits 15..1 only if test mode was already on before that write. Otherwise the force register keeps its content, which can be read at select 3.
- R8: Force bits take part in the request only while test mode is on. Turning test mode off hides them without erasing them.
- R9: An acknowledge of level n (1..15) clears force bit n if test mode is on and force bit n is set, and leaves pending bit n alone in that case. In every other case it clears pending bit n. An acknowledge of level 0 does nothing. A source event at n in the same cycle keeps pending bit n set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 16 | Per-level event strobes, bit n for level n |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 mask, 2 clear, 3 force, 4 test control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read select: 0 mask, 1 pending, 3 force, 4 test control |
| rd_data | output | 32 | Combinational read data for `rd_sel` |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Registered highest-priority request level, 0 when idle |
| par_err | output | 1 | One-cycle pulse after a mask write with illegal bits |

## Verification
A wrong pending, mask or force bit appears on `rd_data` in the same cycle the register is selected. It also appears on `irq_level` one cycle after the bad edge, whenever that bit is the highest unmasked one. An acknowledge that retires the wrong register shows in one of two ways. Either the request code stays at the acknowledged level a cycle longer than expected, or it drops while a forced or pending copy should still hold it. A lost or spurious parity pulse shows on the cycle right after the mask write. Random traffic that often acknowledges the level on display, mixed with directed cases for level 15, for test-mode toggling and for collisions between events and clears, makes each of these visible within one or two cycles.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int IRQ_LEVELS    = 16;
    localparam int IRQ_DATA_W    = 32;
    localparam int IRQ_TMODE_BIT = 19;

    typedef enum logic [2:0] {
        SEL_MASK  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_CLEAR = 3'd2,
        SEL_FORCE = 3'd3,
        SEL_TCTL  = 3'd4
    } irq_sel_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = 4
) (
    input  logic [NUM_LVL-1:1] vec,
    output logic [LVL_W-1:0]   level
);

    // Scan upward so that the highest set bit is the last one assigned.
    always_comb begin
        level = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (vec[i]) begin
                level = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_LVL   = IRQ_LEVELS,
    parameter int DATA_W    = IRQ_DATA_W,
    parameter int TMODE_BIT = IRQ_TMODE_BIT,
    parameter int LVL_W     = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] src_evt,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [2:0]         rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [NUM_LVL-1:0] pend_o,
    output logic [NUM_LVL-1:0] mask_o,
    output logic [NUM_LVL-1:0] force_o,
    output logic               tmode_o,
    output logic               par_err_o
);

    localparam logic [NUM_LVL-1:0] LVL_BITS  = {{(NUM_LVL-1){1'b1}}, 1'b0};
    localparam logic [NUM_LVL-1:0] MASK_BITS = {1'b0, {(NUM_LVL-2){1'b1}}, 1'b0};
    localparam logic [DATA_W-1:0]  BAD_BITS  =
        {{(DATA_W-NUM_LVL+1){1'b1}}, {(NUM_LVL-2){1'b0}}, 1'b1};

    logic [NUM_LVL-1:0] pend_q, mask_q, force_q;
    logic [NUM_LVL-1:0] pend_d, mask_d, force_d;
    logic               tmode_q, tmode_d;
    logic               par_q, par_d;
    logic [NUM_LVL-1:0] ack_vec, frc_clr, pnd_clr, sw_clr;
    irq_sel_e           wsel, rsel;

    assign wsel = irq_sel_e'(wr_sel);
    assign rsel = irq_sel_e'(rd_sel);

    // Next-state logic for all register groups.
    always_comb begin
        ack_vec = (ack_valid && ack_level != '0)
                ? ({{(NUM_LVL-1){1'b0}}, 1'b1} << ack_level) : '0;
        frc_clr = (tmode_q && |(force_q & ack_vec)) ? ack_vec : '0;
        pnd_clr = (frc_clr == '0) ? ack_vec : '0;
        sw_clr  = (wr_en && wsel == SEL_CLEAR)
                ? (wr_data[NUM_LVL-1:0] & LVL_BITS) : '0;

        pend_d  = ((pend_q & ~sw_clr & ~pnd_clr) | src_evt) & LVL_BITS;
        force_d = (wr_en && wsel == SEL_FORCE && tmode_q)
                ? (wr_data[NUM_LVL-1:0] & LVL_BITS) : (force_q & ~frc_clr);
        mask_d  = (wr_en && wsel == SEL_MASK)
                ? (wr_data[NUM_LVL-1:0] & MASK_BITS) : mask_q;
        tmode_d = (wr_en && wsel == SEL_TCTL) ? wr_data[TMODE_BIT] : tmode_q;
        par_d   = wr_en && (wsel == SEL_MASK) && |(wr_data & BAD_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            force_q <= '0;
            mask_q  <= MASK_BITS;
            tmode_q <= 1'b0;
            par_q   <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            force_q <= force_d;
            mask_q  <= mask_d;
            tmode_q <= tmode_d;
            par_q   <= par_d;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_MASK:  rd_data = DATA_W'(mask_q);
            SEL_PEND:  rd_data = DATA_W'(pend_q);
            SEL_FORCE: rd_data = DATA_W'(force_q);
            SEL_TCTL:  rd_data[TMODE_BIT] = tmode_q;
            default:   rd_data = '0;
        endcase
    end

    assign pend_o    = pend_q;
    assign mask_o    = mask_q;
    assign force_o   = force_q;
    assign tmode_o   = tmode_q;
    assign par_err_o = par_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LVL   = IRQ_LEVELS,
    parameter int DATA_W    = IRQ_DATA_W,
    parameter int TMODE_BIT = IRQ_TMODE_BIT,
    parameter int LVL_W     = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] src_evt,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [2:0]         rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [LVL_W-1:0]   irq_level,
    output logic               par_err
);

    logic [NUM_LVL-1:0] pend_q, mask_q, force_q, eff_vec;
    logic               tmode_q;
    logic [LVL_W-1:0]   enc_lvl;

    irq_regs #(
        .NUM_LVL   (NUM_LVL),
        .DATA_W    (DATA_W),
        .TMODE_BIT (TMODE_BIT),
        .LVL_W     (LVL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .force_o   (force_q),
        .tmode_o   (tmode_q),
        .par_err_o (par_err)
    );

    // Forced requests count only while test mode is on.
    assign eff_vec = (pend_q | (tmode_q ? force_q : '0)) & ~mask_q
                   & {{(NUM_LVL-1){1'b1}}, 1'b0};

    irq_prio_enc #(
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W)
    ) enc_i (
        .vec   (eff_vec[NUM_LVL-1:1]),
        .level (enc_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level <= '0;
        end else begin
            irq_level <= enc_lvl;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_LVL = 16,
    parameter int DATA_W  = 32,
    parameter int LVL_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_LVL-1:0] src_evt,
    input logic               wr_en,
    input logic [2:0]         wr_sel,
    input logic [DATA_W-1:0]  wr_data,
    input logic               ack_valid,
    input logic [LVL_W-1:0]   ack_level,
    input logic [LVL_W-1:0]   irq_level,
    input logic               par_err,
    input logic [NUM_LVL-1:0] pend_q,
    input logic [NUM_LVL-1:0] force_q,
    input logic               tmode_q,
    input logic [NUM_LVL-1:0] eff_vec
);

    localparam logic [NUM_LVL-1:0] LVL_BITS = {{(NUM_LVL-1){1'b1}}, 1'b0};
    localparam logic [DATA_W-1:0]  BAD_BITS =
        {{(DATA_W-NUM_LVL+1){1'b1}}, {(NUM_LVL-2){1'b0}}, 1'b1};

    logic [NUM_LVL-1:0] eff_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eff_d <= '0;
        else        eff_d <= eff_vec;
    end

    // R2
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_evt & LVL_BITS) != '0)
        |=> ((pend_q & $past(src_evt & LVL_BITS)) == $past(src_evt & LVL_BITS)));

    // R3
    lvl_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> eff_d[irq_level]);

    // R3
    lvl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_d >> irq_level) >> 1) == '0);

    // R5
    par_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0 && |(wr_data & BAD_BITS)) |=> par_err);

    // R5
    par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 3'd0) |=> !par_err);

    // R7
    force_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd3 && !tmode_q && !ack_valid) |=> $stable(force_q));

    // R9
    ack_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != '0 && !tmode_q && !src_evt[ack_level])
        |=> !pend_q[$past(ack_level)]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_LVL (NUM_LVL),
    .DATA_W  (DATA_W),
    .LVL_W   (LVL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .irq_level (irq_level),
    .par_err   (par_err),
    .pend_q    (pend_q),
    .force_q   (force_q),
    .tmode_q   (tmode_q),
    .eff_vec   (eff_vec)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_evt = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic [3:0]  irq_level;
    logic        par_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements.
    logic [15:0] m_pend = '0;
    logic [15:0] m_mask = 16'h7FFE;
    logic [15:0] m_force = '0;
    logic        m_tmode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .irq_level (irq_level),
        .par_err   (par_err)
    );

    function automatic logic [15:0] f_eff();
        return (m_pend | (m_tmode ? m_force : 16'h0)) & ~m_mask & 16'hFFFE;
    endfunction

    function automatic logic [3:0] f_prio(logic [15:0] v);
        for (int i = 15; i > 0; i--) begin
            if (v[i]) return 4'(i);
        end
        return 4'd0;
    endfunction

    function automatic logic [31:0] f_read(logic [2:0] s);
        case (s)
            3'd0:    return {16'h0, m_mask};
            3'd1:    return {16'h0, m_pend};
            3'd3:    return {16'h0, m_force};
            3'd4:    return {12'h0, m_tmode, 19'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string f_rtag(logic [2:0] s);
        case (s)
            3'd0:    return "R4";
            3'd1:    return "R2";
            3'd3:    return "R7";
            3'd4:    return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic peek(logic [2:0] s, string req, logic [31:0] exp);
        rd_sel = s;
        #1;
        check(req, rd_data, exp);
    endtask

    // One clock: update the reference at the edge, compare at the next falling edge.
    task automatic step();
        logic [3:0]  exp_lvl;
        logic        exp_par;
        logic [15:0] pn, fn;
        @(posedge clk);
        exp_lvl = f_prio(f_eff());
        exp_par = wr_en && wr_sel == 3'd0 && ((wr_data & 32'hFFFF_8001) != 0);
        pn = m_pend;
        fn = m_force;
        if (wr_en && wr_sel == 3'd2) pn = pn & ~(wr_data[15:0] & 16'hFFFE);
        if (ack_valid && ack_level != 0) begin
            if (m_tmode && m_force[ack_level]) fn[ack_level] = 1'b0;
            else                               pn[ack_level] = 1'b0;
        end
        pn = (pn | src_evt) & 16'hFFFE;
        if (wr_en && wr_sel == 3'd3 && m_tmode) fn = wr_data[15:0] & 16'hFFFE;
        if (wr_en && wr_sel == 3'd0) m_mask = wr_data[15:0] & 16'h7FFE;
        if (wr_en && wr_sel == 3'd4) m_tmode = wr_data[19];
        m_pend  = pn;
        m_force = fn;
        @(negedge clk);
        check("R3", 32'(irq_level), 32'(exp_lvl));
        check("R5", 32'(par_err), 32'(exp_par));
        check(f_rtag(rd_sel), rd_data, f_read(rd_sel));
        src_evt   = '0;
        wr_en     = 1'b0;
        ack_valid = 1'b0;
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        wr_en   = 1'b1;
        wr_sel  = s;
        wr_data = d;
    endtask

    task automatic ack(logic [3:0] l);
        ack_valid = 1'b1;
        ack_level = l;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R3: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5821));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", 32'(irq_level), 32'd0);
        peek(3'd0, "R1", 32'h0000_7FFE);
        peek(3'd1, "R1", 32'h0);
        peek(3'd3, "R1", 32'h0);
        peek(3'd4, "R1", 32'h0);

        // R2 / R4: level 15 passes the reset mask, bit 0 is dropped
        src_evt = 16'h8001;
        step();
        step();
        check("R4", 32'(irq_level), 32'd15);
        peek(3'd1, "R2", 32'h0000_8000);

        // R9: unmask, add level 3, acknowledge 15
        wr(3'd0, 32'h0);
        src_evt = 16'h0008;
        step();
        ack(4'd15);
        step();
        step();
        check("R9", 32'(irq_level), 32'd3);

        // R5: illegal mask bits pulse once, legal part stored
        wr(3'd0, 32'hFFFF_FFFF);
        step();
        check("R5", 32'(par_err), 32'd1);
        step();
        check("R5", 32'(par_err), 32'd0);
        peek(3'd0, "R4", 32'h0000_7FFE);

        // R7: force write without test mode leaves force empty
        wr(3'd3, 32'h0000_0020);
        step();
        peek(3'd3, "R7", 32'h0);

        // R7 / R8: enable test mode, force level 5, unmask
        wr(3'd4, 32'h0008_0000);
        step();
        wr(3'd3, 32'h0000_0020);
        step();
        peek(3'd3, "R7", 32'h0000_0020);
        wr(3'd0, 32'h0);
        step();
        step();
        check("R8", 32'(irq_level), 32'd5);
        wr(3'd4, 32'h0);
        step();
        step();
        check("R8", 32'(irq_level), 32'd3);

        // R9: forced copy retired first, real pending kept
        wr(3'd4, 32'h0008_0000);
        src_evt = 16'h0020;
        step();
        ack(4'd5);
        step();
        step();
        peek(3'd3, "R9", 32'h0);
        check("R9", 32'(irq_level), 32'd5);
        ack(4'd5);
        step();
        step();
        check("R9", 32'(irq_level), 32'd3);
        ack(4'd0);
        step();
        peek(3'd1, "R9", 32'h0000_0008);

        // R6: clear all while level 1 fires in the same cycle
        wr(3'd2, 32'h0000_FFFF);
        src_evt = 16'h0002;
        step();
        step();
        peek(3'd1, "R6", 32'h0000_0002);
        check("R6", 32'(irq_level), 32'd1);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 3 == 0) src_evt = 16'(1 << ($urandom % 16));
            if ($urandom % 4 == 0) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom % 3 != 0) d = d & 32'h0000_FFFE;
                wr(3'($urandom % 8), d);
            end
            if ($urandom % 3 == 0) ack(($urandom % 2 == 0) ? irq_level : 4'($urandom % 16));
            rd_sel = 3'($urandom % 8);
            step();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule